// File: doc/BRIEF.md
# Dataflow Thread Lifecycle Scheduler

This block tracks non-blocking, fine-grained threads in a decoupled multithreaded core. Each thread owns one activation frame drawn from a fixed pool. When a frame is allocated it is loaded with a synchronization count: the number of input values the thread still waits for. Each data arrival lowers the count by one. At zero the thread becomes enabled and is offered to the memory-side synchronization pipeline for its preload phase.

A fork-to-execute command moves a thread that is preloading into the preloaded queue. That queue feeds the execute pipeline. A predicated fork-to-sync command moves a thread that is executing into the post-store queue. That queue is served again by the synchronization pipeline. A free command returns a frame to the pool from any state. This is how the untaken arm of a conditional is discarded, and also how a finished thread releases its frame. Only frame identifiers, counts and queue membership are held. Frame contents and the pipelines themselves live elsewhere.

Top module: `dflow_sched`

## Requirements
- R1: While at least one frame is free, `alloc_ready` is high and `alloc_fid` names the lowest-numbered free frame. An accepted allocation (`alloc_req` and `alloc_ready` both high) claims that frame.
- R2: A frame allocated with count n is offered for preload after exactly n accepted arrivals (`arr_req` with `arr_fid`). With n = 0 it is offered in the cycle after allocation.
- R3: An enabled thread appears on the sync port with `sp_post` = 0. It leaves the port once `sp_valid` and `sp_ready` are both high.
- R4: `fx_req` acts only on a frame that is preloading, moving it to the preloaded queue. That queue is offered on the execute port (`ep_valid`, `ep_fid`) and is taken with `ep_ready`. On a frame in any other state, `fx_req` has no effect.
- R5: `fs_req` with `fs_pred` = 1 on a frame that is executing moves it to the post-store queue. With `fs_pred` = 0, or on a frame in another state, it has no effect.
- R6: An arrival aimed at a frame that is not waiting (count zero or frame unallocated) sets `arr_err` high in the next cycle and leaves that frame's state unchanged.
- R7: With no free frame, `alloc_ready` is low. It returns high in the cycle after a `free_req`.
- R8: `free_req` returns the named frame to the pool from any state and withdraws it from every queue. `free_req` takes precedence over any other command to the same frame in the same cycle.
- R9: Each queue serves its oldest member first. Frames that enter the same queue in the same cycle are ordered lowest index first.
- R10: The sync port serves the post-store queue before the enabled queue. `sp_post` = 1 marks a post-store dispatch.
- R11: A thread that has been dispatched is never offered again, and never leaves its phase, until a fork or free command moves it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Allocation request |
| alloc_cnt | input | CNT_W | Inputs the new thread expects |
| alloc_ready | output | 1 | A frame is available |
| alloc_fid | output | FID_W | Frame granted to the allocation |
| free_req | input | 1 | Return a frame to the pool |
| free_fid | input | FID_W | Frame to release |
| arr_req | input | 1 | One input value arrived |
| arr_fid | input | FID_W | Frame receiving the value |
| arr_err | output | 1 | Previous arrival hit a non-waiting frame |
| fx_req | input | 1 | Fork to execute |
| fx_fid | input | FID_W | Frame to fork to execute |
| fs_req | input | 1 | Fork to sync (post-store) |
| fs_fid | input | FID_W | Frame to fork to sync |
| fs_pred | input | 1 | Predicate guarding the fork to sync |
| sp_valid | output | 1 | Sync pipeline work offered |
| sp_fid | output | FID_W | Frame offered to sync pipeline |
| sp_post | output | 1 | 1 = post-store, 0 = preload |
| sp_ready | input | 1 | Sync pipeline accepts |
| ep_valid | output | 1 | Execute pipeline work offered |
| ep_fid | output | FID_W | Frame offered to execute pipeline |
| ep_ready | input | 1 | Execute pipeline accepts |

## Verification
The embedded properties assume that every frame identifier presented is within the pool. They also assume that ready inputs are sampled only at clock edges. The properties make no assumption about which state a commanded frame is in, because misdirected forks and arrivals are defined behaviour. The stimulus therefore draws identifiers only from the pool. It deliberately sends arrivals, forks and frees to frames in arbitrary states, so the ignore and error paths are exercised alongside the well-formed lifecycle.

// File: rtl/dts_pkg.sv
package dts_pkg;

    typedef enum logic [2:0] {
        FS_FREE = 3'd0,
        FS_WAIT = 3'd1,
        FS_ENAB = 3'd2,
        FS_PRE  = 3'd3,
        FS_RDY  = 3'd4,
        FS_EXE  = 3'd5,
        FS_PSQ  = 3'd6,
        FS_PST  = 3'd7
    } fstate_t;

    // queue slots used by the age tracker
    localparam int Q_EN  = 0;
    localparam int Q_RDY = 1;
    localparam int Q_PSQ = 2;
    localparam int NQ    = 3;

    function automatic logic is_queued(fstate_t s);
        return (s == FS_ENAB) || (s == FS_RDY) || (s == FS_PSQ);
    endfunction

endpackage

// File: rtl/dts_frame.sv
module dts_frame
    import dts_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_hit,
    input  logic [CNT_W-1:0] alloc_cnt,
    input  logic             free_hit,
    input  logic             arr_hit,
    input  logic             fx_hit,
    input  logic             fs_hit,
    input  logic             sp_take,
    input  logic             ep_take,
    output fstate_t          st,
    output logic             enq
);

    logic [CNT_W-1:0] cnt, ncnt;
    fstate_t          nst;

    always_comb begin
        nst  = st;
        ncnt = cnt;
        if (free_hit) begin
            nst  = FS_FREE;
            ncnt = '0;
        end else begin
            unique case (st)
                FS_FREE: if (alloc_hit) begin
                    ncnt = alloc_cnt;
                    nst  = (alloc_cnt == '0) ? FS_ENAB : FS_WAIT;
                end
                FS_WAIT: if (arr_hit) begin
                    ncnt = cnt - 1'b1;
                    if (cnt == CNT_W'(1)) nst = FS_ENAB;
                end
                FS_ENAB: if (sp_take) nst = FS_PRE;
                FS_PRE:  if (fx_hit)  nst = FS_RDY;
                FS_RDY:  if (ep_take) nst = FS_EXE;
                FS_EXE:  if (fs_hit)  nst = FS_PSQ;
                FS_PSQ:  if (sp_take) nst = FS_PST;
                default: nst = st;
            endcase
        end
        enq = (nst != st) && is_queued(nst);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= FS_FREE;
            cnt <= '0;
        end else begin
            st  <= nst;
            cnt <= ncnt;
        end
    end

    // R2
    enab_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (st == FS_ENAB) |-> (cnt == '0));

    // R11
    exe_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st == FS_EXE && !fs_hit && !free_hit) |=> (st == FS_EXE));

    // R4
    order_chk: assert property (@(posedge clk) disable iff (rst)
        (st != FS_RDY && st != FS_EXE) |=> (st != FS_EXE));

endmodule

// File: rtl/dts_age.sv
module dts_age
    import dts_pkg::*;
#(
    parameter int N = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N-1:0]          enq,
    input  logic [NQ-1:0][N-1:0]  mask,
    output logic [NQ-1:0][N-1:0]  pick
);

    // older[i][j] = 1 when frame i entered its queue before frame j
    logic [N-1:0][N-1:0] older;

    always_ff @(posedge clk) begin
        if (rst) begin
            older <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                for (int j = 0; j < N; j++) begin
                    if (i != j) begin
                        if (enq[i] && enq[j])
                            older[i][j] <= (i < j) ? 1'b1 : 1'b0;
                        else if (enq[i])
                            older[i][j] <= 1'b0;
                        else if (enq[j])
                            older[i][j] <= 1'b1;
                    end
                end
            end
        end
    end

    always_comb begin
        logic blk;
        for (int q = 0; q < NQ; q++) begin
            for (int i = 0; i < N; i++) begin
                blk = 1'b0;
                for (int j = 0; j < N; j++)
                    if (j != i && mask[q][j] && older[j][i]) blk = 1'b1;
                pick[q][i] = mask[q][i] && !blk;
            end
        end
    end

    for (genvar q = 0; q < NQ; q++) begin : g_chk
        // R9
        pick_onehot_chk: assert property (@(posedge clk) disable iff (rst)
            $onehot0(pick[q]));
    end

endmodule

// File: rtl/dflow_sched.sv
module dflow_sched
    import dts_pkg::*;
#(
    parameter int NFRAMES = 8,
    parameter int CNT_W   = 4,
    localparam int FID_W  = $clog2(NFRAMES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             alloc_req,
    input  logic [CNT_W-1:0] alloc_cnt,
    output logic             alloc_ready,
    output logic [FID_W-1:0] alloc_fid,
    input  logic             free_req,
    input  logic [FID_W-1:0] free_fid,
    input  logic             arr_req,
    input  logic [FID_W-1:0] arr_fid,
    output logic             arr_err,
    input  logic             fx_req,
    input  logic [FID_W-1:0] fx_fid,
    input  logic             fs_req,
    input  logic [FID_W-1:0] fs_fid,
    input  logic             fs_pred,
    output logic             sp_valid,
    output logic [FID_W-1:0] sp_fid,
    output logic             sp_post,
    input  logic             sp_ready,
    output logic             ep_valid,
    output logic [FID_W-1:0] ep_fid,
    input  logic             ep_ready
);

    fstate_t                    st [NFRAMES];
    logic [NFRAMES-1:0]         enq, free_m, sp_sel;
    logic [NQ-1:0][NFRAMES-1:0] mask, pick;

    for (genvar i = 0; i < NFRAMES; i++) begin : g_frame
        localparam logic [FID_W-1:0] ME = FID_W'(i);
        dts_frame #(.CNT_W(CNT_W)) u_frame (
            .clk      (clk),
            .rst      (rst),
            .alloc_hit(alloc_req && alloc_ready && (alloc_fid == ME)),
            .alloc_cnt(alloc_cnt),
            .free_hit (free_req && (free_fid == ME)),
            .arr_hit  (arr_req && (arr_fid == ME)),
            .fx_hit   (fx_req && (fx_fid == ME)),
            .fs_hit   (fs_req && fs_pred && (fs_fid == ME)),
            .sp_take  (sp_ready && sp_sel[i]),
            .ep_take  (ep_ready && pick[Q_RDY][i]),
            .st       (st[i]),
            .enq      (enq[i])
        );
        assign free_m[i]      = (st[i] == FS_FREE);
        assign mask[Q_EN][i]  = (st[i] == FS_ENAB);
        assign mask[Q_RDY][i] = (st[i] == FS_RDY);
        assign mask[Q_PSQ][i] = (st[i] == FS_PSQ);
    end

    dts_age #(.N(NFRAMES)) u_age (
        .clk (clk),
        .rst (rst),
        .enq (enq),
        .mask(mask),
        .pick(pick)
    );

    // lowest free frame wins allocation
    always_comb begin
        alloc_fid = '0;
        for (int i = NFRAMES - 1; i >= 0; i--)
            if (free_m[i]) alloc_fid = FID_W'(i);
    end
    assign alloc_ready = |free_m;

    // post-store work outranks preload work on the sync side
    assign sp_post  = |pick[Q_PSQ];
    assign sp_sel   = sp_post ? pick[Q_PSQ] : pick[Q_EN];
    assign sp_valid = |sp_sel;
    assign ep_valid = |pick[Q_RDY];

    always_comb begin
        sp_fid = '0;
        ep_fid = '0;
        for (int i = 0; i < NFRAMES; i++) begin
            if (sp_sel[i])     sp_fid = FID_W'(i);
            if (pick[Q_RDY][i]) ep_fid = FID_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) arr_err <= 1'b0;
        else     arr_err <= arr_req && (st[arr_fid] != FS_WAIT);
    end

    // R7
    alloc_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (!alloc_ready && !free_req) |=> !alloc_ready);

    // R6
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !arr_req |=> !arr_err);

endmodule

// File: tb/sim_dflow_sched.sv
module sim_dflow_sched;
    localparam int NF = 8;
    localparam int CW = 4;
    localparam int FW = 3;
    // bench-side state codes
    localparam int S_FREE = 0, S_WAIT = 1, S_ENAB = 2, S_PRE = 3,
                   S_RDY = 4, S_EXE = 5, S_PSQ = 6, S_PST = 7;

    logic clk = 1'b0, rst = 1'b1;
    logic alloc_req = 0, free_req = 0, arr_req = 0, fx_req = 0, fs_req = 0;
    logic fs_pred = 0, sp_ready = 0, ep_ready = 0;
    logic [CW-1:0] alloc_cnt = '0;
    logic [FW-1:0] free_fid = '0, arr_fid = '0, fx_fid = '0, fs_fid = '0;
    logic alloc_ready, arr_err, sp_valid, sp_post, ep_valid;
    logic [FW-1:0] alloc_fid, sp_fid, ep_fid;

    always #4 clk = ~clk;

    dflow_sched #(.NFRAMES(NF), .CNT_W(CW)) u0 (.*);

    int checks = 0, failures = 0, cycles = 0;
    int mst [NF], mcnt [NF];
    int qen[$], qrdy[$], qpsq[$];
    bit merr = 0;

    task automatic expect_eq(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    function automatic int m_afid();
        for (int i = 0; i < NF; i++) if (mst[i] == S_FREE) return i;
        return -1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NF; i++) begin mst[i] = S_FREE; mcnt[i] = 0; end
        qen.delete(); qrdy.delete(); qpsq.delete(); merr = 0;
    endtask

    task automatic model_step();
        int nst [NF], ncnt [NF];
        int af, spf, epf;
        int keep[$];
        af  = m_afid();
        spf = (qpsq.size() > 0) ? qpsq[0] : ((qen.size() > 0) ? qen[0] : -1);
        epf = (qrdy.size() > 0) ? qrdy[0] : -1;
        merr = arr_req && (mst[arr_fid] != S_WAIT);
        for (int i = 0; i < NF; i++) begin
            nst[i] = mst[i]; ncnt[i] = mcnt[i];
            if (free_req && free_fid == i) begin
                nst[i] = S_FREE; ncnt[i] = 0;
            end else case (mst[i])
                S_FREE: if (alloc_req && af == i) begin
                    ncnt[i] = alloc_cnt; nst[i] = (alloc_cnt == 0) ? S_ENAB : S_WAIT;
                end
                S_WAIT: if (arr_req && arr_fid == i) begin
                    ncnt[i] = mcnt[i] - 1; if (ncnt[i] == 0) nst[i] = S_ENAB;
                end
                S_ENAB: if (sp_ready && spf == i) nst[i] = S_PRE;
                S_PRE:  if (fx_req && fx_fid == i) nst[i] = S_RDY;
                S_RDY:  if (ep_ready && epf == i) nst[i] = S_EXE;
                S_EXE:  if (fs_req && fs_pred && fs_fid == i) nst[i] = S_PSQ;
                S_PSQ:  if (sp_ready && spf == i) nst[i] = S_PST;
                default: ;
            endcase
        end
        keep.delete(); foreach (qen[k])  if (nst[qen[k]]  == S_ENAB) keep.push_back(qen[k]);  qen = keep;
        keep.delete(); foreach (qrdy[k]) if (nst[qrdy[k]] == S_RDY)  keep.push_back(qrdy[k]); qrdy = keep;
        keep.delete(); foreach (qpsq[k]) if (nst[qpsq[k]] == S_PSQ)  keep.push_back(qpsq[k]); qpsq = keep;
        for (int i = 0; i < NF; i++) begin
            if (nst[i] != mst[i]) begin
                if (nst[i] == S_ENAB) qen.push_back(i);
                if (nst[i] == S_RDY)  qrdy.push_back(i);
                if (nst[i] == S_PSQ)  qpsq.push_back(i);
            end
            mst[i] = nst[i]; mcnt[i] = ncnt[i];
        end
    endtask

    task automatic compare_all();
        int af, spf, epf;
        af  = m_afid();
        spf = (qpsq.size() > 0) ? qpsq[0] : ((qen.size() > 0) ? qen[0] : -1);
        epf = (qrdy.size() > 0) ? qrdy[0] : -1;
        expect_eq("R7 alloc_ready", alloc_ready, af >= 0);
        if (af >= 0) expect_eq("R1 alloc_fid", alloc_fid, af);
        expect_eq("R3 sp_valid", sp_valid, spf >= 0);
        if (spf >= 0) begin
            expect_eq("R9 sp_fid", sp_fid, spf);
            expect_eq("R10 sp_post", sp_post, qpsq.size() > 0);
        end
        expect_eq("R4 ep_valid", ep_valid, epf >= 0);
        if (epf >= 0) expect_eq("R9 ep_fid", ep_fid, epf);
        expect_eq("R6 arr_err", arr_err, merr);
    endtask

    task automatic clear_in();
        alloc_req = 0; free_req = 0; arr_req = 0; fx_req = 0; fs_req = 0;
        fs_pred = 0; sp_ready = 0; ep_ready = 0;
    endtask

    task automatic step();
        model_step();
        @(posedge clk);
        @(negedge clk);
        cycles++;
        compare_all();
        clear_in();
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // reset state
        expect_eq("R1 reset alloc_ready", alloc_ready, 1);
        expect_eq("R1 reset alloc_fid", alloc_fid, 0);
        expect_eq("R3 reset sp_valid", sp_valid, 0);
        expect_eq("R4 reset ep_valid", ep_valid, 0);
        expect_eq("R6 reset arr_err", arr_err, 0);

        alloc_req = 1; alloc_cnt = 2; step();
        arr_req = 1; arr_fid = 0; step();
        expect_eq("R2 one arrival short", sp_valid, 0);
        arr_req = 1; arr_fid = 0; step();
        expect_eq("R2 enabled at zero", sp_valid, 1);
        expect_eq("R3 preload offer", sp_post, 0);
        arr_req = 1; arr_fid = 0; sp_ready = 1; step();
        expect_eq("R6 arrival at zero", arr_err, 1);
        expect_eq("R11 no re-offer", sp_valid, 0);
        fx_req = 1; fx_fid = 1; step();
        expect_eq("R4 fork to free frame ignored", ep_valid, 0);
        fx_req = 1; fx_fid = 0; step();
        expect_eq("R4 fork to exec", ep_valid, 1);
        ep_ready = 1; step();
        expect_eq("R11 exec taken", ep_valid, 0);
        fs_req = 1; fs_fid = 0; fs_pred = 0; step();
        expect_eq("R5 false predicate", sp_valid, 0);
        fs_req = 1; fs_fid = 0; fs_pred = 1; step();
        expect_eq("R5 true predicate", sp_post, 1);
        alloc_req = 1; alloc_cnt = 0; step();
        expect_eq("R10 post-store first", sp_fid, 0);
        expect_eq("R10 post flag", sp_post, 1);
        sp_ready = 1; step();
        expect_eq("R10 preload after post", sp_fid, 1);
        free_req = 1; free_fid = 1; step();
        expect_eq("R8 freed leaves queue", sp_valid, 0);
        expect_eq("R8 freed frame reusable", alloc_fid, 1);
        free_req = 1; free_fid = 0; step();
        // age order: allocate 0,1,2 then enable 2 before 0
        for (int k = 0; k < 3; k++) begin alloc_req = 1; alloc_cnt = 1; step(); end
        arr_req = 1; arr_fid = 2; step();
        arr_req = 1; arr_fid = 0; step();
        expect_eq("R9 oldest first", sp_fid, 2);
        // fill the pool
        for (int k = 0; k < 6; k++) begin alloc_req = 1; alloc_cnt = 3; step(); end
        expect_eq("R7 pool empty", alloc_ready, 0);
        free_req = 1; free_fid = 5; step();
        expect_eq("R7 ready after free", alloc_ready, 1);
        expect_eq("R7 freed frame granted", alloc_fid, 5);

        // mixed traffic compared on every cycle
        for (int c = 0; c < 4000; c++) begin
            alloc_req = ($urandom % 10) < 3;
            alloc_cnt = CW'($urandom % 4);
            arr_req   = ($urandom % 2) == 0;
            arr_fid   = FW'($urandom % NF);
            fx_req    = ($urandom % 10) < 4;
            fx_fid    = FW'($urandom % NF);
            fs_req    = ($urandom % 10) < 4;
            fs_fid    = FW'($urandom % NF);
            fs_pred   = ($urandom % 4) != 0;
            free_req  = ($urandom % 10) < 2;
            free_fid  = FW'($urandom % NF);
            sp_ready  = ($urandom % 2) == 0;
            ep_ready  = ($urandom % 2) == 0;
            step();
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=0", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule